// File: doc/BRIEF.md
# SPI Command Parser

This block sits behind a byte-wide SPI slave and turns streams of received bytes into register, FIFO and memory operations. Every command starts with a one-byte opcode. The opcode is followed by a short header and then by data words. The slave reports each byte with two strobes. `xfer_begin` marks the start of a byte, and the block must present the byte to shift out during that cycle. `xfer_end` marks the moment a received byte is valid on `rx_byte`.

The block contains everything it operates on: a bank of 16-bit registers, a small 16-bit FIFO, a 16-bit word memory, and an enable flag that drives an output pin. The host reaches this state only through the opcodes below. A controller sequences the bytes through wait steps and one-cycle action steps. A wait step holds until a strobe arrives. An action step does its work in one cycle and then moves to the next wait step.

Top module: `spi_cmd_parser`

## Requirements
- R1: After reset, `func_en` is 0, `tx_byte` is 0, the FIFO is empty and every register reads back 0.
- R2: A one-byte command 0x01 sets `func_en` to 1, and 0x00 clears it. No other command changes `func_en`.
- R3: Command 0x02 is followed by a register index byte and two data bytes, and writes that 16-bit value to the register. With `LITTLE_END`=1 (the default) the low byte comes first, and with 0 the high byte comes first. Indices at or above `NREG` (8) are not written.
- R4: Command 0x03 is followed by a register index byte and then two dummy bytes. During those two transfers, `tx_byte` carries the register value in the order given in R3, and it is valid in the cycle `xfer_begin` is high. Indices at or above `NREG` read as 0.
- R5: `tx_byte` is 0 in every cycle that is not the start cycle of a read data transfer. In particular it is 0 throughout all write commands.
- R6: Command 0x04 is followed by a two-byte word count N and then N words of two bytes each. The words are pushed into the FIFO in order.
- R7: A word that arrives while the FIFO holds `FIFO_DEPTH` (4) words is dropped, and the words already stored are kept.
- R8: Command 0x05 is followed by a two-byte count N and then N dummy words. Each word returns the FIFO head and removes it. When the FIFO is empty the word returns 0 and nothing is removed.
- R9: Command 0x06 is followed by a two-byte start address, a two-byte count N and N words. The words are written to consecutive memory addresses.
- R10: Command 0x07 is followed by a two-byte start address, a two-byte count N and N dummy words. Each word returns the memory word at consecutive addresses.
- R11: Memory addresses at or above `MEM_DEPTH` (256) are not written and read as 0. They do not wrap onto low addresses.
- R12: The word count is decremented after each word and then tested. After exactly N words the block is idle, and the next byte, even within the same select, is taken as an opcode. A count of 0 ends the command right after its header.
- R13: After an opcode above 0x07, every byte is ignored until `sel_n` goes high. The block is then idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | SPI select as seen by the slave, active low |
| xfer_begin | input | 1 | One-cycle strobe at the start of a byte transfer |
| xfer_end | input | 1 | One-cycle strobe when `rx_byte` holds the received byte |
| rx_byte | input | 8 | Byte received from the host |
| tx_byte | output | 8 | Byte to send, valid in the `xfer_begin` cycle |
| func_en | output | 1 | Enable flag driven by opcodes 0x00 and 0x01 |

## Verification
The bench runs full byte sequences for each command and compares what comes back on `tx_byte` with values it derives from the requirements.

Overflow is tested by writing six words into a four-word FIFO and reading six back. A design that does not drop the extra words would return 5 and 6 where the bench expects 0, or would corrupt the head. Memory writes that run from the last in-range address into address 256 must leave address 0 intact. A design that wraps the address would overwrite it, and an out-of-range read would then return stale data instead of 0.

A zero count and an unknown opcode are each followed, within the same select, by an enable opcode. A design that waits for data, or that leaves the skip state early, shows a wrong `func_en`. A design that tests the count before decrementing it would take one word too many.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam int BYTE_W  = 8;
  localparam int FIELD_W = 16;

  localparam logic [BYTE_W-1:0] OP_DIS     = 8'h00;
  localparam logic [BYTE_W-1:0] OP_ENA     = 8'h01;
  localparam logic [BYTE_W-1:0] OP_REG_WR  = 8'h02;
  localparam logic [BYTE_W-1:0] OP_REG_RD  = 8'h03;
  localparam logic [BYTE_W-1:0] OP_FIFO_WR = 8'h04;
  localparam logic [BYTE_W-1:0] OP_FIFO_RD = 8'h05;
  localparam logic [BYTE_W-1:0] OP_MEM_WR  = 8'h06;
  localparam logic [BYTE_W-1:0] OP_MEM_RD  = 8'h07;

  // target class = opcode bits [2:1]
  localparam logic [1:0] CL_REG  = 2'b01;
  localparam logic [1:0] CL_FIFO = 2'b10;
  localparam logic [1:0] CL_MEM  = 2'b11;

  typedef enum logic [3:0] {
    S_IDLE, S_OPC_W, S_OPC_A, S_HDR_W, S_HDR_A,
    S_WR_W, S_WR_A, S_RD_B, S_RD_A, S_RD_E,
    S_UPD, S_BR, S_SKIP
  } st_t;

  // index of the final header byte for a target class
  function automatic logic [1:0] hdr_last(input logic [1:0] cls);
    case (cls)
      CL_REG:  return 2'd0;
      CL_FIFO: return 2'd1;
      default: return 2'd3;
    endcase
  endfunction

  // pos is the order of the byte inside its field (0 = first on the wire)
  function automatic logic take_high(input logic pos, input bit le);
    return le ? pos : ~pos;
  endfunction

  function automatic logic [FIELD_W-1:0] put_half(input logic [FIELD_W-1:0] f,
                                                  input logic [BYTE_W-1:0] b,
                                                  input logic pos, input bit le);
    logic [FIELD_W-1:0] r;
    r = f;
    if (take_high(pos, le)) r[FIELD_W-1:BYTE_W] = b;
    else                    r[BYTE_W-1:0]       = b;
    return r;
  endfunction

  function automatic logic [BYTE_W-1:0] pick_half(input logic [FIELD_W-1:0] f,
                                                  input logic pos, input bit le);
    return take_high(pos, le) ? f[FIELD_W-1:BYTE_W] : f[BYTE_W-1:0];
  endfunction

endpackage

// File: rtl/spi_cmd_fifo.sv
module spi_cmd_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic          full,
  output logic          empty,
  output logic [LW-1:0] level
);
  logic [W-1:0]  store [DEPTH];
  logic [AW-1:0] wp, rp;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full  = (level == LW'(DEPTH));
  assign empty = (level == '0);
  assign rdata = store[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push) wp <= step(wp);
      if (pop)  rp <= step(rp);
      case ({push, pop})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) store[wp] <= wdata;
  end
endmodule

// File: rtl/spi_cmd_mem.sv
module spi_cmd_mem #(
  parameter int DEPTH = 256,
  parameter int W     = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] cells [DEPTH];

  assign rdata = cells[addr];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end
endmodule

// File: rtl/spi_cmd_regbank.sv
module spi_cmd_regbank #(
  parameter int NREG = 8,
  parameter int W    = 16,
  parameter int IW   = 16,
  localparam int RAW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  localparam logic [IW:0] LIM = (IW + 1)'(NREG);

  logic [W-1:0] regs [NREG];
  logic         hit;

  assign hit   = ({1'b0, addr} < LIM);
  assign rdata = hit ? regs[addr[RAW-1:0]] : '0;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   regs[i] <= '0;
      else if (we && hit && addr[RAW-1:0] == RAW'(i)) regs[i] <= wdata;
    end
  end
endmodule

// File: rtl/spi_cmd_fsm.sv
module spi_cmd_fsm
  import spi_cmd_pkg::*;
#(
  parameter int NREG      = 8,
  parameter int MEM_DEPTH = 256,
  parameter bit LITTLE_END = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_n,
  input  logic               xfer_begin,
  input  logic               xfer_end,
  input  logic [BYTE_W-1:0]  rx_byte,
  output logic [BYTE_W-1:0]  tx_byte,
  output logic               func_en,
  output logic [FIELD_W-1:0] acc_addr,
  output logic [FIELD_W-1:0] acc_wdata,
  output logic               reg_we,
  input  logic [FIELD_W-1:0] reg_rdata,
  output logic               fifo_push,
  output logic               fifo_pop,
  input  logic [FIELD_W-1:0] fifo_rdata,
  input  logic               fifo_full,
  input  logic               fifo_empty,
  output logic               mem_we,
  input  logic [FIELD_W-1:0] mem_rdata,
  output st_t                st_o,
  output logic [FIELD_W-1:0] cnt_o
);
  localparam logic [FIELD_W:0] MEM_LIM = (FIELD_W + 1)'(MEM_DEPTH);

  st_t                st, nxt;
  logic [BYTE_W-1:0]  opc_q;
  logic [FIELD_W-1:0] addr_q, cnt_q, wd_q, rd_word;
  logic [1:0]         hix_q, cls;
  logic               bsel_q, en_q, is_rd, mem_ok, upd;

  assign cls    = opc_q[2:1];
  assign is_rd  = opc_q[0];
  assign mem_ok = ({1'b0, addr_q} < MEM_LIM);
  assign upd    = (st == S_UPD);

  always_comb begin
    nxt = st;
    case (st)
      S_IDLE:  if (xfer_begin) nxt = S_OPC_W;
      S_OPC_W: if (xfer_end)   nxt = S_OPC_A;
      S_OPC_A: begin
        if (opc_q == OP_DIS || opc_q == OP_ENA) nxt = S_IDLE;
        else if (opc_q <= OP_MEM_RD)            nxt = S_HDR_W;
        else                                    nxt = S_SKIP;
      end
      S_HDR_W: if (xfer_end) nxt = S_HDR_A;
      S_HDR_A: begin
        if (hix_q != hdr_last(cls)) nxt = S_HDR_W;
        else if (cnt_q == '0)       nxt = S_IDLE;
        else if (is_rd)             nxt = S_RD_B;
        else                        nxt = S_WR_W;
      end
      S_WR_W:  if (xfer_end) nxt = S_WR_A;
      S_WR_A:  nxt = bsel_q ? S_UPD : S_WR_W;
      S_RD_B:  if (xfer_begin) nxt = S_RD_A;
      S_RD_A:  nxt = S_RD_E;
      S_RD_E:  if (xfer_end) nxt = bsel_q ? S_UPD : S_RD_B;
      S_UPD:   nxt = S_BR;
      S_BR: begin
        if (cnt_q == '0) nxt = S_IDLE;
        else if (is_rd)  nxt = S_RD_B;
        else             nxt = S_WR_W;
      end
      S_SKIP:  if (sel_n) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      opc_q  <= '0;
      addr_q <= '0;
      cnt_q  <= '0;
      wd_q   <= '0;
      hix_q  <= '0;
      bsel_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      st <= nxt;
      case (st)
        S_OPC_W: if (xfer_end) opc_q <= rx_byte;
        S_OPC_A: begin
          hix_q  <= '0;
          bsel_q <= 1'b0;
          addr_q <= '0;
          cnt_q  <= (cls == CL_REG) ? FIELD_W'(1) : '0;
          if (opc_q == OP_DIS)      en_q <= 1'b0;
          else if (opc_q == OP_ENA) en_q <= 1'b1;
        end
        S_HDR_W: if (xfer_end) begin
          case (cls)
            CL_REG:  addr_q <= {{(FIELD_W-BYTE_W){1'b0}}, rx_byte};
            CL_FIFO: cnt_q  <= put_half(cnt_q, rx_byte, hix_q[0], LITTLE_END);
            default: begin
              if (!hix_q[1]) addr_q <= put_half(addr_q, rx_byte, hix_q[0], LITTLE_END);
              else           cnt_q  <= put_half(cnt_q,  rx_byte, hix_q[0], LITTLE_END);
            end
          endcase
        end
        S_HDR_A: hix_q <= hix_q + 2'd1;
        S_WR_W:  if (xfer_end) wd_q <= put_half(wd_q, rx_byte, bsel_q, LITTLE_END);
        S_WR_A:  bsel_q <= ~bsel_q;
        S_RD_E:  if (xfer_end) bsel_q <= ~bsel_q;
        S_UPD: begin
          cnt_q <= cnt_q - FIELD_W'(1);
          if (cls == CL_MEM) addr_q <= addr_q + FIELD_W'(1);
        end
        default: ;
      endcase
    end
  end

  // source of the word returned by a read command
  always_comb begin
    case (opc_q)
      OP_REG_RD:  rd_word = reg_rdata;
      OP_FIFO_RD: rd_word = fifo_empty ? '0 : fifo_rdata;
      OP_MEM_RD:  rd_word = mem_ok ? mem_rdata : '0;
      default:    rd_word = '0;
    endcase
  end

  // byte is offered from the next state so it is ready in the start cycle
  assign tx_byte   = (nxt == S_RD_A) ? pick_half(rd_word, bsel_q, LITTLE_END) : '0;
  assign reg_we    = upd && (opc_q == OP_REG_WR);
  assign fifo_push = upd && (opc_q == OP_FIFO_WR) && !fifo_full;
  assign fifo_pop  = upd && (opc_q == OP_FIFO_RD) && !fifo_empty;
  assign mem_we    = upd && (opc_q == OP_MEM_WR) && mem_ok;
  assign acc_addr  = addr_q;
  assign acc_wdata = wd_q;
  assign func_en   = en_q;
  assign st_o      = st;
  assign cnt_o     = cnt_q;
endmodule

// File: rtl/spi_cmd_parser.sv
module spi_cmd_parser
  import spi_cmd_pkg::*;
#(
  parameter int NREG       = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int MEM_DEPTH  = 256,
  parameter bit LITTLE_END = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_n,
  input  logic       xfer_begin,
  input  logic       xfer_end,
  input  logic [7:0] rx_byte,
  output logic [7:0] tx_byte,
  output logic       func_en
);
  localparam int MAW = $clog2(MEM_DEPTH);
  localparam int FLW = $clog2(FIFO_DEPTH + 1);

  logic [FIELD_W-1:0] acc_addr, acc_wdata, reg_rdata, fifo_rdata, mem_rdata, word_cnt;
  logic               reg_we, fifo_push, fifo_pop, fifo_full, fifo_empty, mem_we;
  logic [FLW-1:0]     fifo_level;
  st_t                fsm_state;

  spi_cmd_fsm #(.NREG(NREG), .MEM_DEPTH(MEM_DEPTH), .LITTLE_END(LITTLE_END)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n),
    .xfer_begin(xfer_begin), .xfer_end(xfer_end), .rx_byte(rx_byte),
    .tx_byte(tx_byte), .func_en(func_en),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata),
    .fifo_push(fifo_push), .fifo_pop(fifo_pop), .fifo_rdata(fifo_rdata),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .mem_we(mem_we), .mem_rdata(mem_rdata),
    .st_o(fsm_state), .cnt_o(word_cnt)
  );

  spi_cmd_regbank #(.NREG(NREG), .W(FIELD_W), .IW(FIELD_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(acc_addr),
    .wdata(acc_wdata), .rdata(reg_rdata)
  );

  spi_cmd_fifo #(.DEPTH(FIFO_DEPTH), .W(FIELD_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(fifo_push), .wdata(acc_wdata),
    .pop(fifo_pop), .rdata(fifo_rdata), .full(fifo_full),
    .empty(fifo_empty), .level(fifo_level)
  );

  spi_cmd_mem #(.DEPTH(MEM_DEPTH), .W(FIELD_W)) u_mem (
    .clk(clk), .we(mem_we), .addr(acc_addr[MAW-1:0]),
    .wdata(acc_wdata), .rdata(mem_rdata)
  );
endmodule

// File: rtl/spi_cmd_parser_chk.sv
module spi_cmd_parser_chk
  import spi_cmd_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int MEM_DEPTH  = 256,
  localparam int FLW       = $clog2(FIFO_DEPTH + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sel_n,
  input logic               xfer_begin,
  input logic [7:0]         tx_byte,
  input logic               func_en,
  input st_t                st,
  input logic [FIELD_W-1:0] cnt,
  input logic [FLW-1:0]     fifo_level,
  input logic               fifo_pop,
  input logic               fifo_empty,
  input logic               mem_we,
  input logic [FIELD_W-1:0] mem_addr
);
  localparam logic [FIELD_W:0] MEM_LIM = (FIELD_W + 1)'(MEM_DEPTH);
  localparam logic [FLW-1:0]   F_LIM   = FLW'(FIFO_DEPTH);

  a_r2_en_only_by_opcode: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_OPC_A) |=> $stable(func_en));

  a_r5_tx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_byte != 8'h00) |-> xfer_begin);

  a_r7_fifo_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= F_LIM);

  a_r8_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !fifo_empty);

  a_r11_mem_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ({1'b0, mem_addr} < MEM_LIM));

  a_r12_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_UPD) |=> (cnt == $past(cnt) - FIELD_W'(1)));

  a_r13_skip_release: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SKIP && sel_n) |=> (st == S_IDLE));
endmodule

bind spi_cmd_parser spi_cmd_parser_chk #(.FIFO_DEPTH(FIFO_DEPTH), .MEM_DEPTH(MEM_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .xfer_begin(xfer_begin),
  .tx_byte(tx_byte), .func_en(func_en), .st(fsm_state), .cnt(word_cnt),
  .fifo_level(fifo_level), .fifo_pop(fifo_pop), .fifo_empty(fifo_empty),
  .mem_we(mem_we), .mem_addr(acc_addr)
);

// File: tb/spi_cmd_parser_test.sv
module spi_cmd_parser_test;
  logic       clk = 1'b0;
  logic       rst_n, sel_n, xfer_begin, xfer_end;
  logic [7:0] rx_byte, tx_byte;
  logic       func_en;
  int         vectors = 0;
  int         miscompares = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  spi_cmd_parser uut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .xfer_begin(xfer_begin),
    .xfer_end(xfer_end), .rx_byte(rx_byte), .tx_byte(tx_byte), .func_en(func_en)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] mo, output logic [7:0] mi);
    @(negedge clk);
    xfer_begin = 1'b1;
    #1 mi = tx_byte;
    @(negedge clk);
    xfer_begin = 1'b0;
    repeat (2) @(negedge clk);
    rx_byte  = mo;
    xfer_end = 1'b1;
    @(negedge clk);
    xfer_end = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // byte of a write-type sequence: nothing may come back (R5)
  task automatic put(input logic [7:0] b);
    logic [7:0] mi;
    xfer(b, mi);
    chk("R5 tx quiet", {8'h00, mi}, 16'h0000);
  endtask

  task automatic put_w(input logic [15:0] w);
    put(w[7:0]);
    put(w[15:8]);
  endtask

  task automatic get_w(output logic [15:0] w);
    logic [7:0] lo, hi;
    xfer(8'h00, lo);
    xfer(8'h00, hi);
    w = {hi, lo};
  endtask

  task automatic open_sel();
    @(negedge clk);
    sel_n = 1'b0;
  endtask

  task automatic close_sel();
    @(negedge clk);
    sel_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic one_op(input logic [7:0] op);
    open_sel(); put(op); close_sel();
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [15:0] v);
    open_sel(); put(8'h02); put(a); put_w(v); close_sel();
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [15:0] v);
    open_sel(); put(8'h03); put(a); get_w(v); close_sel();
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R1 func_en", {15'd0, func_en}, 16'h0000);
    chk("R1 tx_byte", {8'h00, tx_byte}, 16'h0000);
    reg_rd(8'd0, v);
    chk("R1 reg0", v, 16'h0000);
    open_sel(); put(8'h05); put_w(16'd1); get_w(v); close_sel();
    chk("R1 fifo empty", v, 16'h0000);
  endtask

  task automatic t_enable();
    one_op(8'h01);
    chk("R2 enable", {15'd0, func_en}, 16'h0001);
    reg_wr(8'd2, 16'h0001);
    chk("R2 held by other cmd", {15'd0, func_en}, 16'h0001);
    one_op(8'h00);
    chk("R2 disable", {15'd0, func_en}, 16'h0000);
  endtask

  task automatic t_regs();
    logic [15:0] v;
    reg_wr(8'd3, 16'hBEEF);
    reg_wr(8'd5, 16'h00C3);
    reg_rd(8'd3, v);
    chk("R3/R4 reg3", v, 16'hBEEF);
    reg_rd(8'd5, v);
    chk("R3/R4 reg5", v, 16'h00C3);
    reg_wr(8'd9, 16'h1234);
    reg_rd(8'd9, v);
    chk("R4 out-of-range read", v, 16'h0000);
    reg_rd(8'd1, v);
    chk("R3 out-of-range no alias", v, 16'h0000);
  endtask

  task automatic t_fifo();
    logic [15:0] v;
    open_sel(); put(8'h04); put_w(16'd3);
    put_w(16'h1111); put_w(16'h2222); put_w(16'h3333); close_sel();
    open_sel(); put(8'h05); put_w(16'd3);
    get_w(v); chk("R6/R8 word0", v, 16'h1111);
    get_w(v); chk("R6/R8 word1", v, 16'h2222);
    get_w(v); chk("R6/R8 word2", v, 16'h3333);
    close_sel();
  endtask

  task automatic t_fifo_full();
    logic [15:0] v;
    open_sel(); put(8'h04); put_w(16'd6);
    for (int i = 1; i <= 6; i++) put_w(16'(i * 16'h0101));
    close_sel();
    open_sel(); put(8'h05); put_w(16'd6);
    for (int i = 1; i <= 6; i++) begin
      get_w(v);
      if (i <= 4) chk("R7 kept word", v, 16'(i * 16'h0101));
      else        chk("R7/R8 dropped, empty reads 0", v, 16'h0000);
    end
    close_sel();
  endtask

  task automatic t_mem();
    logic [15:0] v;
    open_sel(); put(8'h06); put_w(16'h0000); put_w(16'd1); put_w(16'h0A0A); close_sel();
    open_sel(); put(8'h06); put_w(16'h0010); put_w(16'd3);
    put_w(16'hA001); put_w(16'hB002); put_w(16'hC003); close_sel();
    open_sel(); put(8'h07); put_w(16'h0010); put_w(16'd3);
    get_w(v); chk("R9/R10 addr 0x10", v, 16'hA001);
    get_w(v); chk("R9/R10 addr 0x11", v, 16'hB002);
    get_w(v); chk("R9/R10 addr 0x12", v, 16'hC003);
    close_sel();
  endtask

  task automatic t_mem_range();
    logic [15:0] v;
    open_sel(); put(8'h06); put_w(16'h00FF); put_w(16'd2);
    put_w(16'h7777); put_w(16'h8888); close_sel();
    open_sel(); put(8'h07); put_w(16'h00FF); put_w(16'd2);
    get_w(v); chk("R11 last valid addr", v, 16'h7777);
    get_w(v); chk("R11 addr 256 reads 0", v, 16'h0000);
    close_sel();
    open_sel(); put(8'h07); put_w(16'h0000); put_w(16'd1);
    get_w(v); chk("R11 no wrap onto addr 0", v, 16'h0A0A);
    close_sel();
    open_sel(); put(8'h07); put_w(16'h0100); put_w(16'd1);
    get_w(v); chk("R11 high read 0", v, 16'h0000);
    close_sel();
  endtask

  task automatic t_count_edges();
    logic [15:0] v;
    open_sel(); put(8'h04); put_w(16'd0); put(8'h01); close_sel();
    chk("R12 zero count then opcode", {15'd0, func_en}, 16'h0001);
    open_sel(); put(8'h03); put(8'd3); get_w(v); put(8'h00); close_sel();
    chk("R12 read ends after N words", v, 16'hBEEF);
    chk("R12 next byte is opcode", {15'd0, func_en}, 16'h0000);
  endtask

  task automatic t_unknown();
    open_sel(); put(8'h5A); put(8'h01); put(8'h01);
    chk("R13 bytes ignored", {15'd0, func_en}, 16'h0000);
    close_sel();
    one_op(8'h01);
    chk("R13 idle after release", {15'd0, func_en}, 16'h0001);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sel_n = 1'b1; xfer_begin = 1'b0; xfer_end = 1'b0; rx_byte = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_regs();
    t_fifo();
    t_fifo_full();
    t_mem();
    t_mem_range();
    t_count_edges();
    t_unknown();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule